// File: doc/BRIEF.md
# FIFO Status Channel Scheduler

This block drives the two-bit FIFO status channel that a SPI-4.2 receive port sends back to its transmitter. It emits one status word on every clock. A programmable calendar names a port in each slot, and that port's two-bit FIFO fill status is sent in the slot. The calendar is played a programmable number of times in a row. A DIP-2 parity word and a `11` framing word then close the frame. An optional calendar-selection word may follow the framing word. When a programmable interval has run out, a burst of deskew training patterns is inserted at the next frame boundary.

Configuration (calendar length, repetition count, training interval and repeat count, selection enable and code) is captured once per frame, on the framing word. A calendar block therefore never changes shape partway through. Calendar slots are held in a small memory that is written through a simple write port. Port status values are sampled live, in the slot that names the port.

Top module: `fifo_status_sched`

## Requirements
- R1: While `rst` is high, `stat_o` is `11` and `frm_o` is 0. The first frame after reset uses the defaults: length field 7, repeat field 1, selection off, training interval 0 and training repeat 0. This gives 16 calendar words, then DIP-2, then `11`.
- R2: Calendar slot k carries `port_status[2p+1:2p]`, where p is the port number last written to slot k through `cal_we`/`cal_waddr`/`cal_wport`.
- R3: A frame sends slots 0 to L in order (L is the length field), repeated M+1 times in total (M is the repeat field), and then the DIP-2 word.
- R4: DIP-2 rule: an accumulator is cleared on each framing word. For every covered word w it becomes {acc[0],acc[1]} XOR w. The DIP-2 word sent is the bitwise inverse of the accumulator.
- R5: The DIP-2 word is followed by exactly one `11` word, and `frm_o` is high in exactly that cycle.
- R6: If the selection enable captured on a framing word is 1, the next word is `cfg_sel_code`. That word is covered by the following DIP-2.
- R7: All `cfg_*` inputs are captured on the framing word cycle. Changes at any other time have no effect before the next framing word.
- R8: Count the words sent since reset or since the end of the last training burst. If that count is at least interval×256 at a frame boundary, the block sends (alpha+1) training repetitions before the next calendar. A frame boundary is the point after the framing word, or after the selection word when one is sent. Each repetition is ten `00` words then ten `11` words. The count then restarts.
- R9: A training interval of 0 never produces training.
- R10: Training words are not covered by DIP-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_status | input | 2*NUM_PORTS | Two-bit FIFO status per port, port p at bits 2p+1:2p |
| cal_we | input | 1 | Calendar slot write enable |
| cal_waddr | input | LEN_W | Calendar slot to write |
| cal_wport | input | PORT_W | Port number stored in the slot |
| cfg_len | input | LEN_W | Calendar length minus one |
| cfg_m | input | M_W | Calendar repeats minus one |
| cfg_alpha | input | ALPHA_W | Training repetitions minus one |
| cfg_interval | input | IVL_W | Training interval in units of 256 words, 0 = off |
| cfg_sel_en | input | 1 | Insert a selection word after framing |
| cfg_sel_code | input | 2 | Value of the selection word |
| stat_o | output | 2 | Status word of this cycle |
| frm_o | output | 1 | High while `stat_o` holds the framing word |

## Verification
Each output word is registered once after the state that produces it. Word k after reset therefore appears on the (k+1)th rising edge after `rst` falls, and the bench samples it at the falling edge that follows. The bench builds the whole expected word and marker stream for each configuration from the requirements, including the default first frame and the training position. It then compares that stream word for word. Configuration changes are applied at a falling edge partway through a frame, so the new values take effect only from the next framing-word capture.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [2:0] {ST_CAL, ST_DIP, ST_FRM, ST_SEL, ST_TRN} fss_state_e;

  localparam logic [1:0] FRAME_WORD = 2'b11;

  function automatic logic [1:0] swap2(input logic [1:0] v);
    return {v[0], v[1]};
  endfunction
endpackage

// File: rtl/fss_cal_ram.sv
module fss_cal_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fss_dip2.sv
module fss_dip2 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [1:0] word,
  output logic [1:0] dip
);
  import fss_pkg::*;
  logic [1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= 2'b00;
    else if (upd)   acc <= swap2(acc) ^ word;
  end

  assign dip = ~acc;
endmodule

// File: rtl/fss_train_timer.sv
module fss_train_timer #(
  parameter int IVL_W     = 24,
  parameter int UNIT_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [IVL_W-1:0] interval,
  output logic             due
);
  localparam int CW = IVL_W + UNIT_LOG2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + CW'(1);
  end

  assign lim = {interval, {UNIT_LOG2{1'b0}}};
  assign due = (interval != '0) && (cnt >= lim - CW'(1));

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !due);
endmodule

// File: rtl/fifo_status_sched.sv
module fifo_status_sched #(
  parameter int NUM_PORTS  = 16,
  parameter int CAL_DEPTH  = 128,
  parameter int M_W        = 8,
  parameter int ALPHA_W    = 8,
  parameter int IVL_W      = 24,
  parameter int UNIT_LOG2  = 8,
  parameter int TRAIN_HALF = 10,
  parameter int LEN_W      = $clog2(CAL_DEPTH),
  parameter int PORT_W     = $clog2(NUM_PORTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*NUM_PORTS-1:0] port_status,
  input  logic                   cal_we,
  input  logic [LEN_W-1:0]       cal_waddr,
  input  logic [PORT_W-1:0]      cal_wport,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic [M_W-1:0]         cfg_m,
  input  logic [ALPHA_W-1:0]     cfg_alpha,
  input  logic [IVL_W-1:0]       cfg_interval,
  input  logic                   cfg_sel_en,
  input  logic [1:0]             cfg_sel_code,
  output logic [1:0]             stat_o,
  output logic                   frm_o
);
  import fss_pkg::*;

  localparam int PH_W = $clog2(2 * TRAIN_HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * TRAIN_HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(TRAIN_HALF);

  fss_state_e state, state_nx;
  logic [LEN_W-1:0]   slot, len_sh;
  logic [M_W-1:0]     rep, m_sh;
  logic [ALPHA_W-1:0] trep, alpha_sh;
  logic [PH_W-1:0]    phase;
  logic [IVL_W-1:0]   ivl_sh, eff_ivl;
  logic [1:0]         sel_code_sh;
  logic [PORT_W-1:0]  rd_port;
  logic [1:0]         word, dip_w;
  logic               due, slot_last, rep_last, train_last;

  fss_cal_ram #(.DEPTH(CAL_DEPTH), .AW(LEN_W), .DW(PORT_W)) u_cal (
    .clk(clk), .we(cal_we), .waddr(cal_waddr), .wdata(cal_wport),
    .raddr(slot), .rdata(rd_port));

  fss_dip2 u_dip (
    .clk(clk), .rst(rst), .clr(state == ST_FRM),
    .upd(state == ST_CAL || state == ST_SEL), .word(word), .dip(dip_w));

  assign eff_ivl    = (state == ST_FRM) ? cfg_interval : ivl_sh;
  assign train_last = (state == ST_TRN) && (phase == PH_LAST) && (trep == alpha_sh);

  fss_train_timer #(.IVL_W(IVL_W), .UNIT_LOG2(UNIT_LOG2)) u_tmr (
    .clk(clk), .rst(rst), .restart(train_last), .interval(eff_ivl), .due(due));

  assign slot_last = (slot == len_sh);
  assign rep_last  = (rep == m_sh);

  always_comb begin
    word = FRAME_WORD;
    unique case (state)
      ST_CAL: word = port_status[{rd_port, 1'b0} +: 2];
      ST_DIP: word = dip_w;
      ST_FRM: word = FRAME_WORD;
      ST_SEL: word = sel_code_sh;
      ST_TRN: word = (phase < PH_HALF) ? 2'b00 : 2'b11;
      default: word = FRAME_WORD;
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CAL: if (slot_last && rep_last) state_nx = ST_DIP;
      ST_DIP: state_nx = ST_FRM;
      ST_FRM: state_nx = cfg_sel_en ? ST_SEL : (due ? ST_TRN : ST_CAL);
      ST_SEL: state_nx = due ? ST_TRN : ST_CAL;
      ST_TRN: if (train_last) state_nx = ST_CAL;
      default: state_nx = ST_CAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CAL;
      slot  <= '0;
      rep   <= '0;
      phase <= '0;
      trep  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_CAL) begin
        slot <= slot_last ? '0 : slot + LEN_W'(1);
        if (slot_last) rep <= rep_last ? '0 : rep + M_W'(1);
      end
      if (state == ST_TRN) begin
        phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
        if (phase == PH_LAST) trep <= (trep == alpha_sh) ? '0 : trep + ALPHA_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_sh      <= LEN_W'(7);
      m_sh        <= M_W'(1);
      alpha_sh    <= '0;
      ivl_sh      <= '0;
      sel_code_sh <= 2'b00;
    end else if (state == ST_FRM) begin
      len_sh      <= cfg_len;
      m_sh        <= cfg_m;
      alpha_sh    <= cfg_alpha;
      ivl_sh      <= cfg_interval;
      sel_code_sh <= cfg_sel_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= FRAME_WORD;
      frm_o  <= 1'b0;
    end else begin
      stat_o <= word;
      frm_o  <= (state == ST_FRM);
    end
  end

  assert_frame_word_R5: assert property (@(posedge clk) disable iff (rst)
    frm_o |-> stat_o == FRAME_WORD);
  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CAL) |-> slot <= len_sh);
  assert_sel_after_frame_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEL) |-> $past(state) == ST_FRM);
  assert_train_enabled_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRN) |-> ivl_sh != '0);
  assert_train_no_parity_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRN) |=> $stable(dip_w));
endmodule

// File: tb/fifo_status_sched_tb.sv
module fifo_status_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 16;
  localparam int RUN = 800;

  typedef struct packed {
    logic [6:0]  len;
    logic [7:0]  m;
    logic        sel;
    logic [1:0]  code;
    logic [7:0]  alpha;
    logic [23:0] ivl;
    logic [3:0]  seed;
  } cfg_t;

  localparam cfg_t SCN [6] = '{
    '{7'd3,   8'd0, 1'b0, 2'b00, 8'd0, 24'd0, 4'd1},
    '{7'd7,   8'd2, 1'b1, 2'b10, 8'd0, 24'd0, 4'd3},
    '{7'd3,   8'd0, 1'b0, 2'b00, 8'd1, 24'd1, 4'd5},
    '{7'd0,   8'd0, 1'b1, 2'b01, 8'd0, 24'd1, 4'd7},
    '{7'd11,  8'd1, 1'b0, 2'b00, 8'd2, 24'd2, 4'd2},
    '{7'd127, 8'd0, 1'b0, 2'b00, 8'd0, 24'd0, 4'd6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NP-1:0] port_status = '0;
  logic cal_we = 1'b0;
  logic [6:0] cal_waddr = '0;
  logic [3:0] cal_wport = '0;
  logic [6:0] cfg_len = '0;
  logic [7:0] cfg_m = '0;
  logic [7:0] cfg_alpha = '0;
  logic [23:0] cfg_interval = '0;
  logic cfg_sel_en = 1'b0;
  logic [1:0] cfg_sel_code = '0;
  logic [1:0] stat_o;
  logic frm_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [1:0] exp_w [RUN];
  logic       exp_f [RUN];
  logic [3:0] cal_tab [128];
  int idx, p;
  logic [1:0] acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_status_sched u_dut (
    .clk(clk), .rst(rst), .port_status(port_status), .cal_we(cal_we),
    .cal_waddr(cal_waddr), .cal_wport(cal_wport), .cfg_len(cfg_len),
    .cfg_m(cfg_m), .cfg_alpha(cfg_alpha), .cfg_interval(cfg_interval),
    .cfg_sel_en(cfg_sel_en), .cfg_sel_code(cfg_sel_code),
    .stat_o(stat_o), .frm_o(frm_o));

  function automatic logic [1:0] pstat(input int port, input int seed);
    return 2'((port * seed + (port >> 2)) & 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic emit(input logic [1:0] w, input logic f, input logic cov);
    if (idx < RUN) begin
      exp_w[idx] = w;
      exp_f[idx] = f;
    end
    idx++;
    p++;
    if (cov) acc = {acc[0], acc[1]} ^ w;
  endtask

  // Expected stream from requirements R1..R10: frame 0 uses defaults,
  // frames numbered >= sw use b, earlier ones a.
  task automatic build(input cfg_t a, input cfg_t b, input int sw);
    cfg_t cur;
    int frame;
    cur = '{7'd7, 8'd1, 1'b0, 2'b00, 8'd0, 24'd0, a.seed};
    idx = 0; p = 0; acc = 2'b00; frame = 0;
    while (idx < RUN) begin
      for (int r = 0; r <= int'(cur.m); r++)
        for (int s = 0; s <= int'(cur.len); s++)
          emit(pstat(int'(cal_tab[s]), int'(a.seed)), 1'b0, 1'b1);
      emit(~acc, 1'b0, 1'b0);
      emit(2'b11, 1'b1, 1'b0);
      acc = 2'b00;
      frame++;
      cur = (frame >= sw) ? b : a;
      if (cur.sel) emit(cur.code, 1'b0, 1'b1);
      if (cur.ivl != 0 && p >= int'(cur.ivl) * 256) begin
        for (int t = 0; t <= int'(cur.alpha); t++)
          for (int ph = 0; ph < 20; ph++)
            emit((ph < 10) ? 2'b00 : 2'b11, 1'b0, 1'b0);
        p = 0;
      end
    end
  endtask

  task automatic apply_cfg(input cfg_t c);
    cfg_len = c.len; cfg_m = c.m; cfg_alpha = c.alpha;
    cfg_interval = c.ivl; cfg_sel_en = c.sel; cfg_sel_code = c.code;
  endtask

  // Reset, load table and statuses, apply config a; optionally switch to b
  // at word 20, then compare RUN words against the model.
  task automatic run(input cfg_t a, input cfg_t b, input int sw, input string tag);
    int bad_w, bad_f, first;
    logic [1:0] fa, fe;
    rst = 1'b1;
    apply_cfg(a);
    for (int q = 0; q < NP; q++) port_status[2*q +: 2] = pstat(q, int'(a.seed));
    @(negedge clk);
    for (int k = 0; k < 128; k++) begin
      cal_tab[k] = 4'((k * (2 * int'(a.seed) + 1) + int'(a.seed)) & 15);
      cal_we = 1'b1; cal_waddr = 7'(k); cal_wport = cal_tab[k];
      @(negedge clk);
    end
    cal_we = 1'b0;
    check({tag, " R1 reset word"}, 32'(stat_o), 32'(2'b11));
    check({tag, " R1 reset marker"}, 32'(frm_o), 32'd0);
    build(a, b, sw);
    rst = 1'b0;
    bad_w = 0; bad_f = 0; first = -1; fa = 0; fe = 0;
    for (int i = 0; i < RUN; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (stat_o !== exp_w[i]) begin
        if (first < 0) begin first = i; fa = stat_o; fe = exp_w[i]; end
        bad_w++;
      end
      if (frm_o !== exp_f[i]) bad_f++;
      if (i == 19 && sw > 1) apply_cfg(b);
    end
    n_chk++;
    if (bad_w != 0) begin
      n_bad++;
      $display("FAIL %s R2 R3 R4 R6 R7 R8 R9 R10 stream word %0d actual=%0h expected=%0h",
               tag, first, fa, fe);
    end
    check({tag, " R5 marker mismatches"}, 32'(bad_f), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_t chg;
    repeat (3) @(negedge clk);
    // Table walk: R1 default frame, R2/R3 ordering, R4 parity, R6 select,
    // R8 training (scenarios 2..4), R9 no training with interval 0.
    for (int s = 0; s < 6; s++) run(SCN[s], SCN[s], 1, $sformatf("scn%0d", s));
    // R7: change configuration mid-frame; frame 1 keeps the old shape.
    chg = '{7'd5, 8'd1, 1'b1, 2'b11, 8'd0, 24'd1, 4'd1};
    run(SCN[0], chg, 2, "cfg_change_R7");
    // R9: interval 0 with nonzero alpha never trains.
    chg = '{7'd1, 8'd0, 1'b0, 2'b00, 8'd3, 24'd0, 4'd4};
    run(chg, chg, 1, "no_train_R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule